// File: doc/BRIEF.md
# DMA Channel Register Block

This block holds the software-visible state of one DMA channel behind a 32-bit slave port that takes only full-word accesses. It has four word registers. The first is control/status. The second is the current transfer address. The third is a byte count. The fourth is an upper-address base. Reads are combinational from the stored words, so they need no wait states. Writes take effect at the next rising clock edge.

The control/status word gathers several behaviours:

- a fixed version field that software cannot alter;
- an interrupt pending bit that tracks a level input from the attached peripheral;
- an interrupt enable that gates the pending bit onto the CPU interrupt line;
- a drain bit with a self-inverting write rule;
- a peripheral reset bit that fires a one-cycle pulse;
- a DMA-enable bit that drives a level output;
- a loaded flag that is set whenever software writes the address register.

A transfer-done strobe from the transfer engine adds the completed byte length to the address register. A bus write to the address register in the same cycle takes priority over the strobe. The default configuration decodes a 32-byte window. In that window, offsets 0x10 to 0x1F alias onto the same four registers.

Top module: `dma_chan_regs`

## Requirements
- R1: The register index is byte offset bits [3:2]: 0 = control/status, 1 = address, 2 = count, 3 = base. Offset bits [1:0] and all bits above bit 3 are ignored, so offsets 0x10 to 0x1F alias the registers at 0x00 to 0x0F. Count and base are plain 32-bit read/write storage.
- R2: After reset, control/status reads 0xA0000000 and the address, count and base registers read 0. The outputs cpu_irq, periph_rst and dma_en are all 0.
- R3: Reads return the stored word in the same cycle, with no wait state. In control/status, bits [31:25] and [2:0] ignore bus writes. Every control/status write ORs in 0xA0000000.
- R4: Control/status bit 0 (pending) equals the periph_irq level sampled at the previous rising edge.
- R5: cpu_irq is high exactly when control/status bit 0 (pending) and bit 4 (enable) are both set.
- R6: A control/status write with bit 7 set drives periph_rst high for the one cycle after the write edge. Bit 7 is also stored. A write with bit 7 clear leaves periph_rst low.
- R7: Control/status bit 6 (drain) follows a write rule with three cases. If bit 7 is clear and bit 6 is set, bit 6 is stored as 0. A write of all zeros stores bit 6 as 1. In every other case bit 6 is stored as written.
- R8: dma_en equals control/status bit 9, so it follows the bit 9 value of each control/status write.
- R9: Any write to the address register sets control/status bit 26 (loaded). Control/status writes cannot clear this bit.
- R10: A cycle with xfer_done high adds xfer_len, zero-extended, to the address register, wrapping modulo 2^32. If the address register is written in the same cycle, the written value is stored and the strobe is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Slave access select |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | OFF_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the indexed register |
| periph_irq | input | 1 | Interrupt level from the peripheral |
| cpu_irq | output | 1 | Interrupt to the CPU |
| periph_rst | output | 1 | One-cycle reset pulse to the peripheral |
| dma_en | output | 1 | DMA enable level |
| xfer_done | input | 1 | A peripheral transfer has completed |
| xfer_len | input | LEN_W | Byte length of the completed transfer |

## Verification
The bench builds the block with a 5-bit offset (the 32-byte window) and an 8-bit transfer length. With a 5-bit offset, every one of the eight word slots and nonzero low offset bits can be swept, which exposes both the aliasing and the index decode. The 8-bit length lets the bench reach address wraparound with small strobes and step across the full range of lengths. A list of control/status words covers every branch of the drain, reset and enable rules. All combinations of interrupt level and enable are also driven.

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int OFF_W = 5,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [OFF_W-1:0] bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             periph_irq,
  output logic             cpu_irq,
  output logic             periph_rst,
  output logic             dma_en,
  input  logic             xfer_done,
  input  logic [LEN_W-1:0] xfer_len
);
  localparam logic [31:0] VER_BITS = 32'hA000_0000;
  localparam logic [31:0] RO_MASK  = 32'hFE00_0007;
  localparam int PAD_W = 32 - LEN_W;

  logic [31:0] csr_q, addr_q, cnt_q, base_q;
  logic [31:0] wval, csr_d;
  logic        rst_q;

  wire [1:0] idx     = bus_addr[3:2];
  wire       wr      = bus_sel & bus_wr;
  wire       wr_csr  = wr & (idx == 2'd0);
  wire       wr_addr = wr & (idx == 2'd1);
  wire       wr_cnt  = wr & (idx == 2'd2);
  wire       wr_base = wr & (idx == 2'd3);
  wire [31:0] len_ext = {{PAD_W{1'b0}}, xfer_len};

  always_comb begin
    wval = bus_wdata;
    if (!bus_wdata[7]) begin
      if (bus_wdata[6]) wval[6] = 1'b0;
      else if (bus_wdata == 32'd0) wval[6] = 1'b1;
    end
  end

  always_comb begin
    csr_d = wr_csr ? ((csr_q & RO_MASK) | (wval & ~RO_MASK) | VER_BITS) : csr_q;
    csr_d[0] = periph_irq;
    if (wr_addr) csr_d[26] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr_q  <= VER_BITS;
      addr_q <= '0;
      cnt_q  <= '0;
      base_q <= '0;
      rst_q  <= 1'b0;
    end else begin
      csr_q <= csr_d;
      rst_q <= wr_csr & bus_wdata[7];
      if (wr_addr)        addr_q <= bus_wdata;
      else if (xfer_done) addr_q <= addr_q + len_ext;
      if (wr_cnt)  cnt_q  <= bus_wdata;
      if (wr_base) base_q <= bus_wdata;
    end
  end

  always_comb begin
    case (idx)
      2'd0:    bus_rdata = csr_q;
      2'd1:    bus_rdata = addr_q;
      2'd2:    bus_rdata = cnt_q;
      default: bus_rdata = base_q;
    endcase
  end

  assign cpu_irq    = csr_q[0] & csr_q[4];
  assign periph_rst = rst_q;
  assign dma_en     = csr_q[9];

  a_r3_ro_kept: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(wr_csr) |-> csr_q[31:27] == $past(csr_q[31:27]) && csr_q[2:1] == $past(csr_q[2:1]));

  a_r4_pending: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> csr_q[0] == $past(periph_irq));

  a_r5_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $rose(cpu_irq) |-> $past(periph_irq) || $past(wr_csr && bus_wdata[4]));

  a_r6_rst_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && periph_rst |-> $past(wr_csr && bus_wdata[7]));

  a_r8_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(wr_csr) |-> dma_en == $past(bus_wdata[9]));

  a_r9_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(wr_addr) |-> csr_q[26]);

  a_r10_advance: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(xfer_done && !wr_addr) |-> addr_q == $past(addr_q) + $past(len_ext));
endmodule

// File: tb/tb_dma_chan_regs.sv
`timescale 1ns/1ps
module tb_dma_chan_regs;
  logic        clk = 0, rst_n = 0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [4:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        periph_irq = 0, cpu_irq, periph_rst, dma_en;
  logic        xfer_done = 0;
  logic [7:0]  xfer_len = 0;

  int checks = 0, errors = 0;
  logic [31:0] e_reg [4];
  logic        rst_seen;

  always #2.5 clk = ~clk;

  dma_chan_regs #(.OFF_W(5), .LEN_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .periph_irq(periph_irq), .cpu_irq(cpu_irq),
    .periph_rst(periph_rst), .dma_en(dma_en), .xfer_done(xfer_done), .xfer_len(xfer_len));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] csr_model(input logic [31:0] old, input logic [31:0] v);
    logic [31:0] s = v;
    if (!v[7]) begin
      if (v[6]) s[6] = 1'b0;
      else if (v == 32'd0) s[6] = 1'b1;
    end
    return (old & 32'hFE00_0007) | (s & 32'h01FF_FFF8) | 32'hA000_0000;
  endfunction

  task automatic do_write(input logic [4:0] off, input logic [31:0] d, input logic xd, input logic [7:0] xl);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = off; bus_wdata = d; xfer_done = xd; xfer_len = xl;
    @(negedge clk);
    rst_seen = periph_rst;
    bus_sel = 0; bus_wr = 0; xfer_done = 0;
    case (off[3:2])
      2'd0: e_reg[0] = csr_model(e_reg[0], d);
      2'd1: begin e_reg[1] = d; e_reg[0][26] = 1'b1; end
      default: e_reg[off[3:2]] = d;
    endcase
    if (xd && off[3:2] != 2'd1) e_reg[1] = e_reg[1] + {24'd0, xl};
  endtask

  task automatic do_xfer(input logic [7:0] xl);
    @(negedge clk);
    xfer_done = 1; xfer_len = xl;
    @(negedge clk);
    xfer_done = 0;
    e_reg[1] = e_reg[1] + {24'd0, xl};
  endtask

  task automatic rd_chk(input string req, input logic [4:0] off);
    bus_addr = off; #1;
    chk(req, bus_rdata, e_reg[off[3:2]]);
  endtask

  task automatic set_irq(input logic lvl);
    @(negedge clk);
    periph_irq = lvl;
    @(negedge clk);
    e_reg[0][0] = lvl;
  endtask

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] pats [10];
    pats = '{32'h0, 32'h40, 32'h80, 32'hC0, 32'h10, 32'h200, 32'h210, 32'hFFFF_FFFF, 32'h1, 32'h0C00_0246};
    e_reg[0] = 32'hA000_0000; e_reg[1] = 0; e_reg[2] = 0; e_reg[3] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < 4; i++) rd_chk("R2 reset value", 5'(i * 4));
    chk("R2 cpu_irq reset", {31'd0, cpu_irq}, 0);
    chk("R2 periph_rst reset", {31'd0, periph_rst}, 0);
    chk("R2 dma_en reset", {31'd0, dma_en}, 0);

    for (int k = 0; k < 8; k++) begin
      do_write(5'(k * 4 + (k % 4)), 32'h1234_5600 + 32'(k * 32'h0101_0011), 0, 0);
      for (int j = 0; j < 8; j++) rd_chk("R1 alias/index decode", 5'(j * 4 + (j % 3)));
    end
    chk("R9 loaded after address write", {31'd0, e_reg[0][26]}, 1);

    for (int p = 0; p < 10; p++) begin
      do_write(5'h10, pats[p], 0, 0);
      chk("R6 reset pulse", {31'd0, rst_seen}, {31'd0, pats[p][7]});
      @(negedge clk);
      chk("R6 pulse one cycle", {31'd0, periph_rst}, 0);
      chk("R8 dma_en", {31'd0, dma_en}, {31'd0, pats[p][9]});
      rd_chk("R7 R3 control word", 5'h00);
      chk("R9 loaded kept", {31'd0, bus_rdata[26]}, 1);
    end

    for (int c = 0; c < 4; c++) begin
      do_write(5'h00, c[1] ? 32'h10 : 32'h20, 0, 0);
      set_irq(c[0]);
      rd_chk("R4 pending bit", 5'h00);
      chk("R5 cpu_irq", {31'd0, cpu_irq}, {31'd0, c[0] & c[1]});
    end
    do_write(5'h00, 32'h0000_0006, 0, 0);
    rd_chk("R3 ro low bits", 5'h00);
    set_irq(0);
    chk("R5 cpu_irq drop", {31'd0, cpu_irq}, 0);

    do_write(5'h04, 32'h0000_0100, 0, 0);
    for (int l = 1; l < 256; l += 37) begin
      do_xfer(8'(l));
      rd_chk("R10 address advance", 5'h04);
    end
    do_write(5'h14, 32'hFFFF_FFF0, 0, 0);
    do_xfer(8'h20);
    rd_chk("R10 address wrap", 5'h04);
    chk("R10 wrap value", e_reg[1], 32'h0000_0010);
    do_write(5'h04, 32'h0000_5000, 1, 8'h08);
    rd_chk("R10 bus write priority", 5'h04);
    chk("R10 priority value", e_reg[1], 32'h0000_5000);
    do_write(5'h08, 32'hCAFE_0001, 1, 8'h04);
    rd_chk("R10 strobe with other write", 5'h04);
    rd_chk("R1 count written", 5'h08);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule